// File: doc/BRIEF.md
# Timer Capture and Count-Source Unit

This unit sits beside a timer counter and serves its external capture pins. Each capture input passes through a synchroniser, and its rising and falling edges are then detected. When an edge type enabled for a channel occurs, the channel's capture register takes a snapshot of the timer count supplied on `timer_count`. If that channel's interrupt is enabled, the same event also raises a sticky flag. Software clears a flag by writing a one to its bit.

The same edge detectors drive the count-source selector, which produces the `tick` strobe for the timer core. In timer mode `tick` is held high, so the core advances on every clock. In counter mode `tick` pulses for one clock on each qualifying edge of one chosen capture input. The qualifying edge can be rising, falling or both.

Software reaches the controls and the captured values through a simple register port. A write takes effect at the clock edge. A read is combinational from `rd_addr`.

Top module: `capcnt_unit`

## Requirements
- R1: After reset, every register reads 0, `cap_irq` is all zero, and `tick` is high because count source 0 (timer mode) is selected.
- R2: While count-control bits 1:0 are 0, `tick` is high in every cycle, whatever the capture inputs do.
- R3: In counter mode, count-control bits 3:2 choose which capture input (0 to 3) is the count source. The other inputs do not affect `tick`.
- R4: Count-control bits 1:0 set the count source: 1 counts rising edges, 2 counts falling edges and 3 counts both. An input level that is first sampled at clock edge k gives a one-cycle `tick` pulse between edges k+1 and k+2.
- R5: Capture-control bit 3n enables capture on a rising edge of input n, and bit 3n+1 enables capture on a falling edge. On an enabled edge, at clock edge k+2 the capture register of channel n loads the `timer_count` value present at that edge. Otherwise the capture register holds its value.
- R6: When both edge enables of a channel are set, every transition of that input causes a capture.
- R7: Status bit 4+n (register address 2) is set by a capture event on channel n only when capture-control bit 3n+2 is set. When that bit is clear, the capture register still loads and the flag does not change.
- R8: Writing address 2 clears each status bit written with a one and leaves each bit written with a zero unchanged. A capture event that sets a flag in the same cycle as a clear wins, so the flag stays set.
- R9: The register map is as follows. Address 0 is capture control (bits 11:0). Address 1 is count control (bits 3:0). Address 2 is the status register. Addresses 4+n hold the capture value of channel n and are read-only, so writes to them are ignored. Unused bits and unused addresses read 0.
- R10: `cap_irq[n]` always equals status bit 4+n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_count | input | CNT_W | Current timer count, sampled on capture |
| cap_in | input | NUM_CH | Asynchronous capture inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| tick | output | 1 | Count strobe for the timer core |
| cap_irq | output | NUM_CH | Per-channel capture interrupt flags |

## Verification
A corrupted synchroniser stage or edge history shows up at the ports two clocks after an input transition. The symptom is a missing, extra or shifted `tick` pulse, or a capture value taken from the wrong `timer_count`. A wrong flag or control register is visible on `cap_irq` in the next cycle, or on `rd_data` as soon as the bench addresses it. The bench cycles `rd_addr` through every address, so any stored register that goes wrong is exposed within eight clocks. The reference model predicts all three outputs on every clock, so a single-cycle deviation is caught in the cycle it appears.

// File: rtl/capcnt_pkg.sv
package capcnt_pkg;

   // Count source selection held in count-control bits 1:0
   typedef enum logic [1:0] {
      SRC_CLOCK = 2'd0,
      SRC_RISE  = 2'd1,
      SRC_FALL  = 2'd2,
      SRC_BOTH  = 2'd3
   } cnt_src_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;

   // Register addresses
   localparam int unsigned ADR_CAPCTL  = 0;
   localparam int unsigned ADR_CNTCTL  = 1;
   localparam int unsigned ADR_FLAGS   = 2;
   localparam int unsigned ADR_CAPBASE = 4;

   // Field layout
   localparam int unsigned FLAG_LSB    = 4;
   localparam int unsigned BITS_PER_CH = 3;
   localparam int unsigned CNTCTL_W    = 4;
   localparam int unsigned SEL_W       = 2;

endpackage

// File: rtl/capcnt_edge_det.sv
module capcnt_edge_det
   import capcnt_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  din,
   output edge_t edges
);

   localparam int unsigned DEPTH = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("capcnt_edge_det: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // The first SYNC_STAGES flops synchronise the input; the last flop keeps the previous sample
   logic [DEPTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[DEPTH-2:0], din};
   end

   logic cur_s, old_s;
   assign cur_s = pipe[DEPTH-2];
   assign old_s = pipe[DEPTH-1];

   assign edges.rise = cur_s & ~old_s;
   assign edges.fall = ~cur_s & old_s;

   // R4: a rising edge needs a low sample before it, so it cannot repeat in the next cycle
   a_r4_rise_not_back_to_back : assert property (@(posedge clk) disable iff (!rst_n)
      edges.rise |=> !edges.rise);

   // R4: the same holds for falling edges
   a_r4_fall_not_back_to_back : assert property (@(posedge clk) disable iff (!rst_n)
      edges.fall |=> !edges.fall);

endmodule

// File: rtl/capcnt_capture_slot.sv
module capcnt_capture_slot
   import capcnt_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  edge_t            edges,
   input  logic             en_rise,
   input  logic             en_fall,
   input  logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] value,
   output logic             hit
);

   assign hit = (edges.rise & en_rise) | (edges.fall & en_fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   value <= '0;
      else if (hit) value <= count;
   end

   // R5: an enabled edge loads the count present at that clock edge
   a_r5_load_count : assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (value == $past(count)));

   // R5: without an enabled edge the capture value does not move
   a_r5_hold_value : assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(value));

endmodule

// File: rtl/capcnt_tick_sel.sv
module capcnt_tick_sel
   import capcnt_pkg::*;
#(
   parameter int unsigned NUM_CH = 4
) (
   input  logic [NUM_CH-1:0] rise_v,
   input  logic [NUM_CH-1:0] fall_v,
   input  cnt_src_e          src,
   input  logic [SEL_W-1:0]  sel,
   output logic              tick
);

   logic pick_r, pick_f;

   always_comb begin
      pick_r = 1'b0;
      pick_f = 1'b0;
      for (int n = 0; n < NUM_CH; n++) begin
         if (sel == SEL_W'(n)) begin
            pick_r = rise_v[n];
            pick_f = fall_v[n];
         end
      end
   end

   always_comb begin
      case (src)
         SRC_CLOCK: tick = 1'b1;
         SRC_RISE:  tick = pick_r;
         SRC_FALL:  tick = pick_f;
         SRC_BOTH:  tick = pick_r | pick_f;
         default:   tick = 1'b1;
      endcase
   end

endmodule

// File: rtl/capcnt_unit.sv
module capcnt_unit
   import capcnt_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  timer_count,
   input  logic [NUM_CH-1:0] cap_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              tick,
   output logic [NUM_CH-1:0] cap_irq
);

   localparam int unsigned CAPCTL_W = BITS_PER_CH * NUM_CH;

   generate
      if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
         $error("capcnt_unit: NUM_CH must be 1 to 4");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("capcnt_unit: CNT_W must not exceed DATA_W");
      end
      if (CAPCTL_W > DATA_W || FLAG_LSB + NUM_CH > DATA_W) begin : g_bad_data
         $error("capcnt_unit: DATA_W too small for the control fields");
      end
      if ((1 << ADDR_W) < ADR_CAPBASE + NUM_CH) begin : g_bad_addr
         $error("capcnt_unit: ADDR_W too small for the register map");
      end
   endgenerate

   // Control and status registers
   logic [CAPCTL_W-1:0] capctl;
   logic [CNTCTL_W-1:0] cntctl;
   logic [NUM_CH-1:0]   flags;

   logic wr_capctl, wr_cntctl, wr_flags;
   assign wr_capctl = wr_en && (wr_addr == ADDR_W'(ADR_CAPCTL));
   assign wr_cntctl = wr_en && (wr_addr == ADDR_W'(ADR_CNTCTL));
   assign wr_flags  = wr_en && (wr_addr == ADDR_W'(ADR_FLAGS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         capctl <= '0;
         cntctl <= '0;
      end else begin
         if (wr_capctl) capctl <= wr_data[CAPCTL_W-1:0];
         if (wr_cntctl) cntctl <= wr_data[CNTCTL_W-1:0];
      end
   end

   // Per-channel edge detection and capture
   logic [NUM_CH-1:0] rise_v, fall_v, hit_v, ie_v;
   logic [CNT_W-1:0]  cap_val [NUM_CH];

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
         edge_t ch_edges;

         capcnt_edge_det #(
            .SYNC_STAGES(SYNC_STAGES)
         ) i_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (cap_in[n]),
            .edges(ch_edges)
         );

         capcnt_capture_slot #(
            .CNT_W(CNT_W)
         ) i_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .edges  (ch_edges),
            .en_rise(capctl[BITS_PER_CH*n]),
            .en_fall(capctl[BITS_PER_CH*n+1]),
            .count  (timer_count),
            .value  (cap_val[n]),
            .hit    (hit_v[n])
         );

         assign rise_v[n] = ch_edges.rise;
         assign fall_v[n] = ch_edges.fall;
         assign ie_v[n]   = capctl[BITS_PER_CH*n+2];
      end
   endgenerate

   // Sticky flags: a set in the same cycle overrides a clear
   logic [NUM_CH-1:0] flag_set, flag_clr;
   assign flag_set = hit_v & ie_v;
   assign flag_clr = wr_flags ? wr_data[FLAG_LSB +: NUM_CH] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~flag_clr) | flag_set;
   end

   assign cap_irq = flags;

   // Count source
   cnt_src_e src;
   assign src = cnt_src_e'(cntctl[1:0]);

   capcnt_tick_sel #(
      .NUM_CH(NUM_CH)
   ) i_tick (
      .rise_v(rise_v),
      .fall_v(fall_v),
      .src   (src),
      .sel   (cntctl[3:2]),
      .tick  (tick)
   );

   // Read mux
   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(ADR_CAPCTL)) rd_data[CAPCTL_W-1:0] = capctl;
      if (rd_addr == ADDR_W'(ADR_CNTCTL)) rd_data[CNTCTL_W-1:0] = cntctl;
      if (rd_addr == ADDR_W'(ADR_FLAGS))  rd_data[FLAG_LSB +: NUM_CH] = flags;
      for (int n = 0; n < NUM_CH; n++) begin
         if (rd_addr == ADDR_W'(ADR_CAPBASE + n)) rd_data = DATA_W'(cap_val[n]);
      end
   end

   // R2: timer mode keeps the strobe high
   a_r2_timer_tick_high : assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_CLOCK) |-> tick);

   // R4: in rising-edge mode the strobe is never two cycles wide
   a_r4_rise_tick_single : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && src == SRC_RISE && !wr_cntctl) |=> !tick);

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
         // R7: an enabled interrupt on a capture event sets the flag
         a_r7_flag_sets : assert property (@(posedge clk) disable iff (!rst_n)
            (hit_v[n] && ie_v[n]) |=> flags[n]);

         // R7: a clear flag stays clear without an enabled capture event
         a_r7_flag_quiet : assert property (@(posedge clk) disable iff (!rst_n)
            (!flags[n] && !(hit_v[n] && ie_v[n])) |=> !flags[n]);

         // R8: writing a one clears the flag when no set competes
         a_r8_w1c : assert property (@(posedge clk) disable iff (!rst_n)
            (wr_flags && wr_data[FLAG_LSB+n] && !(hit_v[n] && ie_v[n])) |=> !flags[n]);

         // R8: writing a zero leaves a set flag alone
         a_r8_zero_keeps : assert property (@(posedge clk) disable iff (!rst_n)
            (flags[n] && !(wr_flags && wr_data[FLAG_LSB+n])) |=> flags[n]);
      end
   endgenerate

endmodule

// File: tb/test_capcnt_unit.sv
module test_capcnt_unit;

   localparam int CNT_W  = 32;
   localparam int NUM_CH = 4;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CNT_W-1:0]  timer_count = '0;
   logic [NUM_CH-1:0] cap_in = '0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [DATA_W-1:0] rd_data;
   logic              tick;
   logic [NUM_CH-1:0] cap_irq;

   always #5 clk = ~clk;

   capcnt_unit i_capcnt_unit (
      .clk(clk), .rst_n(rst_n), .timer_count(timer_count), .cap_in(cap_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .tick(tick), .cap_irq(cap_irq)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // Behavioural reference model
   bit [11:0]  m_capctl;
   bit [3:0]   m_cntctl;
   bit [3:0]   m_flags;
   logic [31:0] m_cap [NUM_CH];
   bit hist [NUM_CH][$];   // index 0 = newest sample taken at a clock edge

   function automatic bit m_rise(int n);
      return hist[n][1] && !hist[n][2];
   endfunction

   function automatic bit m_fall(int n);
      return !hist[n][1] && hist[n][2];
   endfunction

   function automatic bit m_tick();
      int ch;
      ch = int'(m_cntctl[3:2]);
      case (m_cntctl[1:0])
         2'd0: return 1'b1;
         2'd1: return m_rise(ch);
         2'd2: return m_fall(ch);
         default: return m_rise(ch) || m_fall(ch);
      endcase
   endfunction

   function automatic logic [31:0] m_read(int a);
      case (a)
         0: return {20'b0, m_capctl};
         1: return {28'b0, m_cntctl};
         2: return {24'b0, m_flags, 4'b0};
         4, 5, 6, 7: return m_cap[a-4];
         default: return 32'b0;
      endcase
   endfunction

   task automatic model_reset();
      m_capctl = '0;
      m_cntctl = '0;
      m_flags  = '0;
      for (int n = 0; n < NUM_CH; n++) begin
         m_cap[n] = '0;
         hist[n].delete();
         repeat (3) hist[n].push_back(1'b0);
      end
   endtask

   // State after the coming clock edge, from the inputs now applied
   task automatic model_advance();
      bit [3:0] setm, clrm;
      bit ev;
      setm = '0;
      for (int n = 0; n < NUM_CH; n++) begin
         ev = (m_rise(n) && m_capctl[3*n]) || (m_fall(n) && m_capctl[3*n+1]);
         if (ev) m_cap[n] = timer_count;
         setm[n] = ev && m_capctl[3*n+2];
      end
      clrm = (wr_en && wr_addr == 3'd2) ? wr_data[7:4] : 4'b0;
      m_flags = (m_flags & ~clrm) | setm;
      if (wr_en && wr_addr == 3'd0) m_capctl = wr_data[11:0];
      if (wr_en && wr_addr == 3'd1) m_cntctl = wr_data[3:0];
      for (int n = 0; n < NUM_CH; n++) begin
         hist[n].push_front(cap_in[n]);
         void'(hist[n].pop_back());
      end
   endtask

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      int a;
      a = int'(rd_addr);
      check(m_cntctl[1:0] == 2'd0 ? "R2 tick" : "R3/R4 tick", {31'b0, tick}, {31'b0, m_tick()});
      check("R7 R10 cap_irq", {28'b0, cap_irq}, {28'b0, m_flags});
      if (a == 2)      check("R8 status read", rd_data, m_read(a));
      else if (a >= 4) check("R5 capture read", rd_data, m_read(a));
      else             check("R9 register read", rd_data, m_read(a));
   endtask

   // One clock: the inputs now applied take effect at the next edge, then compare at the falling edge
   task automatic cyc();
      model_advance();
      @(negedge clk);
      compare();
      rd_addr = rd_addr + 3'd1;
      timer_count = timer_count + 32'd7;
   endtask

   task automatic idle(int n);
      repeat (n) cyc();
   endtask

   task automatic wr(int a, logic [31:0] d);
      wr_en = 1'b1;
      wr_addr = ADDR_W'(a);
      wr_data = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1 tick after reset", {31'b0, tick}, 32'd1);
      check("R1 irq after reset", {28'b0, cap_irq}, 32'd0);
      for (int a = 0; a < 8; a++) begin
         rd_addr = ADDR_W'(a);
         #1;
         check("R1 register after reset", rd_data, 32'd0);
      end
      rd_addr = '0;

      // R2: timer mode ignores input activity
      for (int i = 0; i < 12; i++) begin
         cap_in = NUM_CH'(i);
         cyc();
      end
      cap_in = '0;
      idle(4);

      // R5/R6/R7: ch0 rise+irq, ch1 fall no irq, ch2 both+irq, ch3 rise no irq
      wr(0, {20'b0, 3'b001, 3'b111, 3'b010, 3'b101});
      for (int i = 0; i < 6; i++) begin
         cap_in = 4'b1111;
         idle(5);
         cap_in = 4'b0000;
         idle(5);
      end
      // fast toggles, one per cycle (R6 every transition)
      for (int i = 0; i < 8; i++) begin
         cap_in = cap_in ^ 4'b0101;
         cyc();
      end
      idle(4);

      // R8: clear selected flags with ones, zeros keep
      wr(2, 32'h0000_0010);
      idle(2);
      wr(2, 32'h0000_0000);
      idle(2);
      // clear while a set arrives in the same cycle
      cap_in[0] = 1'b1;
      cyc();
      cyc();
      wr(2, 32'h0000_00F0);
      idle(4);
      cap_in = '0;
      idle(4);

      // R9: writes to capture and unused addresses are ignored
      wr(4, 32'hDEAD_BEEF);
      wr(7, 32'h1234_5678);
      wr(3, 32'hFFFF_FFFF);
      wr(0, 32'hFFFF_FFFF);
      wr(1, 32'hFFFF_FFFF);
      idle(8);

      // R3/R4: each count source on each selected input
      for (int s = 1; s < 4; s++) begin
         for (int ch = 0; ch < NUM_CH; ch++) begin
            wr(1, 32'(ch * 4 + s));
            for (int i = 0; i < 4; i++) begin
               cap_in = cap_in ^ NUM_CH'(1 << ch);
               idle(3);
               cap_in = cap_in ^ NUM_CH'(1 << ((ch + 1) % NUM_CH));
               idle(2);
            end
         end
      end

      // Mixed random phase covering all requirements together
      for (int i = 0; i < 3000; i++) begin
         for (int n = 0; n < NUM_CH; n++)
            if ($urandom % 4 == 0) cap_in[n] = ~cap_in[n];
         if ($urandom % 16 == 0) begin
            wr_en = 1'b1;
            wr_addr = ADDR_W'($urandom % 8);
            wr_data = $urandom;
         end
         cyc();
         wr_en = 1'b0;
      end
      idle(8);
      summary();
   end

endmodule